// File: doc/BRIEF.md
# Six-Channel Linear Volume Ramp with Soft Mute

This block applies a separate linear attenuation to each of six streams of signed audio samples. Every channel has its own 10-bit gain code and its own mute flag, both written through a per-channel strobe. Each incoming 24-bit sample is multiplied by the channel's current applied level, rounded to nearest and limited to the 24-bit range, and then presented one cycle later with an output strobe.

The applied level never jumps. It moves one unit toward its target for each valid sample on that channel. The target is the gain code plus one while the channel is unmuted, and zero while it is muted. A volume change, a mute and a release of mute therefore all fade in or out sample by sample, with no click. A gain code of 1023 gives a level of 1024, which passes the sample through unchanged. After reset every channel is muted at level zero, and its stored gain code is 1023.

Top module: `chan_volume_ramp`

## Requirements
- R1: Each of the six channels keeps its own gain code, mute flag and applied level. A write or a sample on one channel leaves the output of every other channel unchanged. Channel c uses bits [24c+23:24c] of the sample buses, and bit c of the strobe vectors.
- R2: For a valid sample x at applied level L (0 to 1024), the output is x·L/1024 after rounding. When unmuted the target level is code+1, so code 1023 passes x exactly, including -8388608 and 8388607.
- R3: The product is rounded to nearest, with an exact half rounded toward positive infinity (3 at level 512 gives 2, -3 gives -1, -1 gives 0). The result is saturated to the signed 24-bit range.
- R4: On each valid sample, the channel's applied level moves by exactly one toward its target, or stays put if it is already there. Cycles without a valid sample on that channel leave the level unchanged. The sample is scaled by the level held before that step.
- R5: A channel with its mute flag set ramps its level down to zero. While the level is zero, every output of that channel is exactly zero.
- R6: Clearing mute ramps the level back up to the stored code+1, at one unit per valid sample.
- R7: After reset every channel has mute set, level zero and stored gain code 1023. All output strobes and output samples are zero.
- R8: The output strobe of a channel rises in the cycle after its valid input. The channel's output sample keeps its last value until the next valid sample on that channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 6 | Per-channel write strobe for gain code and mute flag |
| cfg_gain | input | 10 | Gain code written to the strobed channels |
| cfg_mute | input | 1 | Mute flag written to the strobed channels |
| in_valid | input | 6 | Per-channel sample strobe |
| in_sample | input | 144 | Six packed signed 24-bit input samples |
| out_valid | output | 6 | Per-channel output strobe, one cycle after input |
| out_sample | output | 144 | Six packed signed 24-bit scaled samples |

## Verification
On every cycle the assertions check several rules. The level never exceeds 1024 and moves by at most one per cycle. It holds still when no sample arrives and steps down whenever a muted channel receives a sample. A zero level always yields a zero output, and the output strobe always follows the input strobe by one cycle. The bench scenarios are the only evidence for the exact arithmetic values, which include the tie-breaking direction of rounding and exact unity at the top code. They also cover the full ramp sequences for a volume change, a mute and a release of mute, channel isolation, and the values present after reset.

// File: rtl/chan_volume_ramp.sv
module chan_volume_ramp #(
  parameter int NCH = 6,
  parameter int DW  = 24,
  parameter int GW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cfg_we,
  input  logic [GW-1:0]     cfg_gain,
  input  logic              cfg_mute,
  input  logic [NCH-1:0]    in_valid,
  input  logic [NCH*DW-1:0] in_sample,
  output logic [NCH-1:0]    out_valid,
  output logic [NCH*DW-1:0] out_sample
);
  localparam int LW = GW + 1;
  localparam int PW = DW + LW + 1;
  localparam logic signed [PW-1:0] HALF = {{(PW-GW){1'b0}}, 1'b1, {(GW-1){1'b0}}};
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [GW-1:0] gain_q [NCH];
  logic          mute_q [NCH];
  logic [LW-1:0] lvl_q  [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [DW-1:0] smp;
    logic signed [PW-1:0] prod, biased, shifted;
    logic [DW-1:0]        scaled;
    logic [LW-1:0]        target, lvl_nx;

    assign smp     = in_sample[c*DW +: DW];
    assign prod    = $signed({{(PW-DW){smp[DW-1]}}, smp}) *
                     $signed({{(PW-LW){1'b0}}, lvl_q[c]});
    assign biased  = prod + HALF;
    assign shifted = biased >>> GW;
    assign scaled  = (shifted > MAXV) ? MAXV[DW-1:0] :
                     (shifted < MINV) ? MINV[DW-1:0] : shifted[DW-1:0];

    assign target  = mute_q[c] ? '0 : ({1'b0, gain_q[c]} + LW'(1));
    assign lvl_nx  = (lvl_q[c] < target) ? lvl_q[c] + LW'(1) :
                     (lvl_q[c] > target) ? lvl_q[c] - LW'(1) : lvl_q[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_q[c] <= '1;
        mute_q[c] <= 1'b1;
        lvl_q[c]  <= '0;
        out_valid[c] <= 1'b0;
        out_sample[c*DW +: DW] <= '0;
      end else begin
        out_valid[c] <= in_valid[c];
        if (cfg_we[c]) begin
          gain_q[c] <= cfg_gain;
          mute_q[c] <= cfg_mute;
        end
        if (in_valid[c]) begin
          lvl_q[c] <= lvl_nx;
          out_sample[c*DW +: DW] <= scaled;
        end
      end
    end

    p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q[c] <= LW'(1 << GW));

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[c] |=> (lvl_q[c] == $past(lvl_q[c]) ||
                       lvl_q[c] == $past(lvl_q[c]) + LW'(1) ||
                       lvl_q[c] == $past(lvl_q[c]) - LW'(1)));

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[c] |=> $stable(lvl_q[c]));

    p_mute_descends_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[c] && mute_q[c] && lvl_q[c] != '0) |=> lvl_q[c] == $past(lvl_q[c]) - LW'(1));

    p_zero_level_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[c] && lvl_q[c] == '0) |=> out_sample[c*DW +: DW] == '0);

    p_strobe_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[c] |=> out_valid[c]);

    p_output_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[c] |=> $stable(out_sample[c*DW +: DW]));
  end
endmodule

// File: tb/tb_chan_volume_ramp.sv
module tb_chan_volume_ramp;
  localparam int NCH = 6;
  localparam int DW  = 24;
  localparam int GW  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    cfg_we = '0;
  logic [GW-1:0]     cfg_gain = '0;
  logic              cfg_mute = 1'b0;
  logic [NCH-1:0]    in_valid = '0;
  logic [NCH*DW-1:0] in_sample = '0;
  logic [NCH-1:0]    out_valid;
  logic [NCH*DW-1:0] out_sample;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chan_volume_ramp #(.NCH(NCH), .DW(DW), .GW(GW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_gain(cfg_gain),
    .cfg_mute(cfg_mute), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample));

  localparam int NV = 10;
  localparam int TV_IN  [NV] = '{3, -3, 1, -1, 0, 1000, 2047, -2047, 8388607, -8388608};
  localparam int TV_EXP [NV] = '{2, -1, 1,  0, 0,  500, 1024, -1023, 4194304, -4194304};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int out_of(int ch);
    logic signed [DW-1:0] v;
    v = out_sample[ch*DW +: DW];
    return int'(v);
  endfunction

  task automatic write_cfg(int ch, int gain, bit mute);
    @(negedge clk);
    cfg_we = NCH'(1) << ch;
    cfg_gain = GW'(gain);
    cfg_mute = mute;
    @(negedge clk);
    cfg_we = '0;
  endtask

  task automatic feed(int ch, int val, output int got, output bit vld);
    @(negedge clk);
    in_valid = NCH'(1) << ch;
    in_sample[ch*DW +: DW] = DW'(val);
    @(negedge clk);
    in_valid = '0;
    got = out_of(ch);
    vld = out_valid[ch];
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int got;
    bit vld;
    int bad;
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R7 out_valid after reset", int'(out_valid), 0);
    check("R7 out_sample after reset", (out_sample == '0) ? 0 : 1, 0);

    feed(0, 1024, got, vld);
    check("R7 muted at reset", got, 0);
    check("R8 strobe follows input", int'(vld), 1);
    feed(0, 1024, got, vld);
    check("R7 level stays zero while muted", got, 0);

    write_cfg(0, 511, 1'b0);
    bad = 0;
    for (int k = 0; k < 512; k++) begin
      feed(0, 1024, got, vld);
      if (got != k) bad++;
    end
    check("R4 ramp up one per sample to 512", bad, 0);

    for (int i = 0; i < NV; i++) begin
      feed(0, TV_IN[i], got, vld);
      check("R3 rounding at level 512", got, TV_EXP[i]);
    end

    feed(1, 1024, got, vld);
    check("R1 channel 1 untouched by channel 0", got, 0);

    write_cfg(1, 1023, 1'b0);
    bad = 0;
    for (int k = 0; k < 1025; k++) begin
      feed(1, 1024, got, vld);
      if (got != k) bad++;
    end
    check("R4 ramp up to unity", bad, 0);

    held = out_of(1);
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (out_valid[1] != 1'b0) bad++;
      if (out_of(1) != held) bad++;
    end
    check("R8 no strobe and output held while idle", bad, 0);
    feed(1, 1024, got, vld);
    check("R4 idle cycles leave level", got, 1024);

    feed(1, 8388607, got, vld);
    check("R2 unity max positive", got, 8388607);
    feed(1, -8388608, got, vld);
    check("R2 unity max negative", got, -8388608);
    feed(1, -12345, got, vld);
    check("R2 unity arbitrary", got, -12345);

    write_cfg(1, 1023, 1'b1);
    bad = 0;
    for (int k = 0; k < 1024; k++) begin
      feed(1, 1024, got, vld);
      if (got != 1024 - k) bad++;
    end
    check("R5 mute ramps down one per sample", bad, 0);
    feed(1, 8388607, got, vld);
    check("R5 zero level gives zero", got, 0);
    feed(1, -8388608, got, vld);
    check("R5 muted stays zero", got, 0);

    write_cfg(1, 1023, 1'b0);
    bad = 0;
    for (int k = 0; k < 1025; k++) begin
      feed(1, 1024, got, vld);
      if (got != k) bad++;
    end
    check("R6 unmute ramps back to stored gain", bad, 0);
    feed(1, 1024, got, vld);
    check("R6 settles at stored gain", got, 1024);

    write_cfg(1, 0, 1'b0);
    bad = 0;
    for (int k = 0; k < 1024; k++) begin
      feed(1, 1024, got, vld);
      if (got != 1024 - k) bad++;
    end
    check("R4 ramp down to code 0", bad, 0);
    feed(1, 8388607, got, vld);
    check("R3 level 1 rounds", got, 8192);
    feed(1, -1536, got, vld);
    check("R3 level 1 negative tie", got, -1);

    feed(0, 1000, got, vld);
    check("R1 channel 0 kept its level", got, 500);
    feed(2, 1024, got, vld);
    check("R1 channel 2 still muted", got, 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule